// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters. All three step on a shared clock-enable pulse (`tickEn`), and each counter drives one output line. Software programs the block over a byte-wide bus. Bus addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is a write-only control register.

A control word selects a channel, a byte-access scheme and one of three waveform modes:

- a one-shot that raises its output at terminal count;
- a rate generator that emits a one-tick low pulse every N ticks;
- a square-wave generator with period N.

The divisor is loaded one byte at a time. A latch command freezes a snapshot of a running counter so that software can read it back one byte at a time while the counter keeps going. A typical use puts one channel in square-wave mode as a periodic system tick and another in one-shot mode as a delay timer.

Top module: `interval_timer3`

## Requirements
- R1: Bus address 3 takes control words. Bits 7:6 select the channel, and the value 3 in that field is ignored. Bits 5:4 select access: 00 is a latch command, 01 transfers the low byte only, 10 the high byte only, and 11 the low byte then the high byte. Bits 3:1 select the mode: codes 2 and 6 give the rate generator, codes 3 and 7 give the square wave, and every other code gives the one-shot. Bit 0 is ignored. Addresses 0 to 2 are the data ports of channels 0 to 2.
- R2: A non-latch control word sets that channel's output to its idle level on the next clock: low for the one-shot, high for the other two modes. The channel then stops counting until its full count has been written. The count is loaded on the first `tickEn` cycle after the final byte of the count.
- R3: With low-then-high access, writes and reads take the low byte first and then the high byte. Low-only access writes the value {0x00, byte}. High-only access writes the value {byte, 0x00}, and reads in that access return the high byte.
- R4: A written count of 0 acts as 65536.
- R5: One-shot: the output goes low when the final count byte is written. It rises on the N-th tick after the load tick and stays high until a new count or control word arrives. Rewriting the count restarts the sequence.
- R6: Rate generator: the output falls once every N ticks and stays low for exactly one tick.
- R7: Square wave with even N: the output is low for N/2 ticks and high for N/2 ticks. The counter steps down by 2 per tick.
- R8: Square wave with odd N: the output is high for (N+1)/2 ticks and low for (N-1)/2 ticks.
- R9: A latch command snapshots the count held before that clock edge, while counting continues. The data port then returns the snapshot until all of its bytes have been read. A second latch command issued while a snapshot is held is ignored.
- R10: In the rate-generator and square-wave modes, a count written while the channel is running takes effect at the next reload.
- R11: Without `tickEn` no channel changes state from counting. A channel is unaffected by traffic addressed to another channel.
- R12: After reset all outputs are low, every channel is a one-shot with low-then-high access, and every count reads 0. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Shared count enable, one tick per high cycle |
| busAddr | input | 2 | Register address (0 to 2 data ports, 3 control) |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (advances the read byte sequence) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from the address |
| chanOut | output | 3 | Per-channel output lines |

## Verification
The assertions check three things on every cycle:

- the idle level that a control word forces on the addressed channel;
- that the outputs are frozen whenever there is neither a tick nor a bus write;
- that address 3 reads as zero.

They also check the output value on leaving reset. The scenarios are the only place where the waveform widths and periods of each mode are checked. The same holds for the exact tick of the one-shot's rise, the 65536 divisor, the deferred reload and the latched snapshot values, because all of these depend on counts and on write history that the ports alone cannot carry from cycle to cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_RATE    = 2'd1,
    MODE_SQUARE  = 2'd2
  } opMode_t;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } access_t;

  // strobes from a channel's control half to its counting half
  typedef struct packed {
    logic             cfgWr;
    opMode_t          newMode;
    logic             cntWr;
    logic [CNT_W-1:0] cntVal;
  } chanStrobe_t;

  function automatic opMode_t decodeMode(input logic [2:0] code);
    if (code[1:0] == 2'b10)      return MODE_RATE;
    else if (code[1:0] == 2'b11) return MODE_SQUARE;
    else                         return MODE_ONESHOT;
  endfunction
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int CW = timer_pkg::CNT_W,
  parameter int BW = timer_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlWr,
  input  logic [4:0]    ctlField,
  input  logic          dataWr,
  input  logic          dataRd,
  input  logic [BW-1:0] wrByte,
  input  logic [CW-1:0] liveCount,
  output logic [BW-1:0] rdByte,
  output opMode_t       mode,
  output chanStrobe_t   strobe
);
  access_t       access;
  access_t       newAccess;
  logic          isLatch;
  logic          isCfg;
  logic          wrHigh;
  logic          rdHigh;
  logic [BW-1:0] lowBuf;
  logic          latchHeld;
  logic [CW-1:0] latchVal;
  logic [CW-1:0] readSrc;

  assign newAccess = access_t'(ctlField[4:3]);
  assign isLatch   = ctlWr && (newAccess == ACC_LATCH);
  assign isCfg     = ctlWr && (newAccess != ACC_LATCH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode      <= MODE_ONESHOT;
      access    <= ACC_LOHI;
      wrHigh    <= 1'b0;
      rdHigh    <= 1'b0;
      lowBuf    <= '0;
      latchHeld <= 1'b0;
      latchVal  <= '0;
    end else if (isCfg) begin
      mode      <= decodeMode(ctlField[2:0]);
      access    <= newAccess;
      wrHigh    <= 1'b0;
      rdHigh    <= 1'b0;
      latchHeld <= 1'b0;
    end else if (isLatch) begin
      rdHigh <= 1'b0;
      if (!latchHeld) begin
        latchHeld <= 1'b1;
        latchVal  <= liveCount;
      end
    end else begin
      if (dataWr && access == ACC_LOHI) begin
        if (!wrHigh) lowBuf <= wrByte;
        wrHigh <= !wrHigh;
      end
      if (dataRd) begin
        if (access == ACC_LOHI) rdHigh <= !rdHigh;
        if (latchHeld && (access != ACC_LOHI || rdHigh)) latchHeld <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.cfgWr   = isCfg;
    strobe.newMode = decodeMode(ctlField[2:0]);
    strobe.cntWr   = dataWr && (access != ACC_LOHI || wrHigh);
    case (access)
      ACC_LO:  strobe.cntVal = {{BW{1'b0}}, wrByte};
      ACC_HI:  strobe.cntVal = {wrByte, {BW{1'b0}}};
      default: strobe.cntVal = {wrByte, lowBuf};
    endcase
  end

  assign readSrc = latchHeld ? latchVal : liveCount;
  assign rdByte  = (access == ACC_HI || (access == ACC_LOHI && rdHigh))
                   ? readSrc[CW-1:BW] : readSrc[BW-1:0];
endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
#(
  parameter int CW = timer_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  opMode_t       mode,
  input  chanStrobe_t   strobe,
  output logic [CW-1:0] count,
  output logic          chanOut
);
  localparam int XW = CW + 1;
  localparam logic [XW-1:0] MAX_DIV = XW'(1) << CW;
  localparam logic [XW-1:0] ONE     = XW'(1);
  localparam logic [XW-1:0] TWO     = XW'(2);

  logic [XW-1:0] cnt;
  logic [XW-1:0] reloadVal;
  logic [XW-1:0] fullN;
  logic [XW-1:0] squareLoad;
  logic [XW-1:0] squareFlip;
  logic          running;
  logic          pending;
  logic          restart;
  logic          outQ;

  assign fullN   = (strobe.cntVal == '0) ? MAX_DIV : {1'b0, strobe.cntVal};
  assign restart = strobe.cntWr && (mode == MODE_ONESHOT || !running);
  // first (high) phase of a square wave: one extra count when N is odd
  assign squareLoad = reloadVal[0] ? reloadVal + ONE : reloadVal;
  // reload at a square-wave phase flip: short low phase, long high phase
  assign squareFlip = !reloadVal[0] ? reloadVal
                    : (outQ ? reloadVal - ONE : reloadVal + ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      reloadVal <= MAX_DIV;
      running   <= 1'b0;
      pending   <= 1'b0;
      outQ      <= 1'b0;
    end else if (strobe.cfgWr) begin
      running <= 1'b0;
      pending <= 1'b0;
      outQ    <= (strobe.newMode != MODE_ONESHOT);
    end else begin
      if (strobe.cntWr) reloadVal <= fullN;
      if (restart) begin
        pending <= 1'b1;
        running <= 1'b0;
        if (mode == MODE_ONESHOT) outQ <= 1'b0;
      end else if (tickEn) begin
        if (pending) begin
          pending <= 1'b0;
          running <= 1'b1;
          cnt     <= (mode == MODE_SQUARE) ? squareLoad : reloadVal;
          outQ    <= (mode != MODE_ONESHOT);
        end else if (running) begin
          case (mode)
            MODE_RATE: begin
              if (cnt == ONE) begin
                cnt  <= reloadVal;
                outQ <= 1'b1;
              end else begin
                cnt <= cnt - ONE;
                if (cnt == TWO) outQ <= 1'b0;
              end
            end
            MODE_SQUARE: begin
              if (cnt <= TWO) begin
                outQ <= !outQ;
                cnt  <= squareFlip;
              end else begin
                cnt <= cnt - TWO;
              end
            end
            default: begin
              cnt <= (cnt == '0) ? (MAX_DIV - ONE) : cnt - ONE;
              if (cnt == ONE) outQ <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign count   = cnt[CW-1:0];
  assign chanOut = outQ;
endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
  import timer_pkg::*;
#(
  parameter int NCH    = timer_pkg::NUM_CH,
  parameter int CW     = timer_pkg::CNT_W,
  parameter int BW     = timer_pkg::BYTE_W,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BW-1:0]     busWrData,
  output logic [BW-1:0]     busRdData,
  output logic [NCH-1:0]    chanOut
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NCH);

  logic          ctlSel;
  logic          unusedBcd;
  logic [BW-1:0] chRd [NCH];

  assign ctlSel    = busWrEn && (busAddr == CTL_ADDR);
  assign unusedBcd = busWrData[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    opMode_t       mode;
    chanStrobe_t   strobe;
    logic [CW-1:0] count;

    timer_ctrl #(.CW(CW), .BW(BW)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .ctlWr    (ctlSel && (busWrData[7:6] == 2'(i))),
      .ctlField (busWrData[5:1]),
      .dataWr   (busWrEn && (busAddr == ADDR_W'(i))),
      .dataRd   (busRdEn && (busAddr == ADDR_W'(i))),
      .wrByte   (busWrData),
      .liveCount(count),
      .rdByte   (chRd[i]),
      .mode     (mode),
      .strobe   (strobe)
    );

    timer_dp #(.CW(CW)) u_dp (
      .clk    (clk),
      .rstN   (rstN),
      .tickEn (tickEn),
      .mode   (mode),
      .strobe (strobe),
      .count  (count),
      .chanOut(chanOut[i])
    );
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NCH; i++)
      if (busAddr == ADDR_W'(i)) busRdData = chRd[i];
  end
endmodule

// File: rtl/interval_timer3_chk.sv
module interval_timer3_chk #(
  parameter int NCH    = 3,
  parameter int BW     = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [BW-1:0]     busWrData,
  input logic [BW-1:0]     busRdData,
  input logic [NCH-1:0]    chanOut
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NCH);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R2: a configuring control word forces the idle level of its mode
    assert_cfg_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && busAddr == CTL_ADDR && busWrData[7:6] == 2'(i) && busWrData[5:4] != 2'b00)
      |=> (chanOut[i] == $past(busWrData[2])));
  end

  // R11: no tick and no bus write means no output change
  assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !busWrEn) |=> $stable(chanOut));

  // R12: the control address reads as zero
  assert_ctl_read_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == CTL_ADDR) |-> (busRdData == '0));

  // R12: outputs are low when leaving reset
  assert_reset_low_R12: assert property (@(posedge clk)
    $rose(rstN) |-> (chanOut == '0));
endmodule

bind interval_timer3 interval_timer3_chk #(.NCH(NCH), .BW(BW), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .chanOut  (chanOut)
);

// File: tb/interval_timer3_tb.sv
module interval_timer3_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic [2:0] chanOut;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  doneFlag = 1'b0;
  int  fallNum [3] = '{0, 0, 0};
  int  riseNum [3] = '{0, 0, 0};
  int  fallAt [3] = '{0, 0, 0};
  int  fallPrev [3] = '{0, 0, 0};
  int  riseAt [3] = '{0, 0, 0};
  logic [2:0] prevOut = 3'b000;

  interval_timer3 u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .chanOut(chanOut)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (prevOut[c] && !chanOut[c]) begin
        fallPrev[c] = fallAt[c];
        fallAt[c]   = cyc;
        fallNum[c]  = fallNum[c] + 1;
      end
      if (!prevOut[c] && chanOut[c]) begin
        riseAt[c]  = cyc;
        riseNum[c] = riseNum[c] + 1;
      end
    end
    prevOut = chanOut;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrByte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdByte(input logic [1:0] a, output logic [7:0] d, output int atCyc);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1;
    d = busRdData; atCyc = cyc;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // mode codes: 0 one-shot, 2 rate, 3 square; access 3 = low then high
  task automatic setup(input int ch, input int acc, input int code);
    wrByte(2'd3, {2'(ch), 2'(acc), 3'(code), 1'b0});
  endtask

  task automatic loadLoHi(input int ch, input int n, output int c0);
    wrByte(2'(ch), 8'(n));
    wrByte(2'(ch), 8'(n >> 8));
    c0 = cyc;
  endtask

  task automatic waitRise(input int ch, input int lim, input string tag);
    int start = riseNum[ch];
    int n = 0;
    while (riseNum[ch] == start && n < lim) begin @(posedge clk); n++; end
    if (riseNum[ch] == start) check({tag, " rise timeout"}, 0, 1);
  endtask

  task automatic waitFall(input int ch, input int lim, input string tag);
    int start = fallNum[ch];
    int n = 0;
    while (fallNum[ch] == start && n < lim) begin @(posedge clk); n++; end
    if (fallNum[ch] == start) check({tag, " fall timeout"}, 0, 1);
  endtask

  task automatic tReset();
    logic [7:0] d; int t;
    check("R12 outputs low after reset", int'(chanOut), 0);
    rdByte(2'd3, d, t);
    check("R12 control address reads 0", int'(d), 0);
    rdByte(2'd0, d, t);
    check("R12 count reads 0", int'(d), 0);
  endtask

  task automatic tOneShot();
    int c0;
    setup(0, 3, 0);
    check("R2 one-shot idle low", int'(chanOut[0]), 0);
    loadLoHi(0, 10, c0);
    waitRise(0, 100, "R5");
    check("R5 one-shot rise tick", riseAt[0] - c0, 11);
    repeat (30) @(negedge clk);
    check("R5 one-shot stays high", int'(chanOut[0]), 1);
    loadLoHi(0, 3, c0);
    check("R5 rewrite drops output", int'(chanOut[0]), 0);
    waitRise(0, 100, "R5");
    check("R5 restart rise tick", riseAt[0] - c0, 4);
  endtask

  task automatic tRate();
    int f0;
    setup(1, 3, 2);
    check("R2 rate idle high", int'(chanOut[1]), 1);
    f0 = fallNum[1];
    wrByte(2'd1, 8'd8);
    repeat (20) @(negedge clk);
    check("R2 no counting on partial count", fallNum[1] - f0, 0);
    check("R2 still idle high", int'(chanOut[1]), 1);
    wrByte(2'd1, 8'd0);
    waitFall(1, 100, "R6");
    waitFall(1, 100, "R6");
    check("R6 rate period", fallAt[1] - fallPrev[1], 8);
    waitRise(1, 100, "R6");
    check("R6 rate low width", riseAt[1] - fallAt[1], 1);
    check("R11 channel 0 undisturbed", int'(chanOut[0]), 1);
  endtask

  task automatic tRateReload();
    int c0;
    waitFall(1, 100, "R10");
    loadLoHi(1, 5, c0);
    waitFall(1, 100, "R10");
    check("R10 current period keeps old N", fallAt[1] - fallPrev[1], 8);
    waitFall(1, 100, "R10");
    check("R10 next period uses new N", fallAt[1] - fallPrev[1], 5);
  endtask

  task automatic tSquare();
    int c0;
    setup(2, 3, 3);
    loadLoHi(2, 6, c0);
    waitFall(2, 100, "R7");
    waitRise(2, 100, "R7");
    check("R7 even low phase", riseAt[2] - fallAt[2], 3);
    waitFall(2, 100, "R7");
    check("R7 even high phase", fallAt[2] - riseAt[2], 3);
    setup(2, 3, 7);
    loadLoHi(2, 7, c0);
    waitFall(2, 100, "R8");
    waitRise(2, 100, "R8");
    check("R8 odd low phase", riseAt[2] - fallAt[2], 3);
    waitFall(2, 100, "R8");
    check("R8 odd high phase", fallAt[2] - riseAt[2], 4);
    check("R1 code 7 periodic falls", fallAt[2] - fallPrev[2], 7);
  endtask

  task automatic tLatch();
    int c0; int cL; int exp; int ta; int tb;
    logic [7:0] lo; logic [7:0] hi;
    setup(2, 3, 2);
    loadLoHi(2, 1000, c0);
    repeat (3) @(negedge clk);
    wrByte(2'd3, 8'h80);
    cL = cyc;
    exp = 1000 - (cL - c0 - 2);
    repeat (4) @(negedge clk);
    wrByte(2'd3, 8'h80);
    rdByte(2'd2, lo, ta);
    rdByte(2'd2, hi, tb);
    check("R9 latched snapshot", int'({hi, lo}), exp);
    rdByte(2'd2, lo, ta);
    check("R9 released low byte live", int'(lo), (1000 - (ta - c0 - 1)) & 255);
    rdByte(2'd2, hi, tb);
    check("R9 released high byte live", int'(hi), (1000 - (tb - c0 - 1)) >> 8);
  endtask

  task automatic tByteModes();
    int c0;
    logic [7:0] d; int t;
    setup(1, 1, 0);
    wrByte(2'd1, 8'h05);
    c0 = cyc;
    waitRise(1, 100, "R3");
    check("R3 low-only count", riseAt[1] - c0, 6);
    setup(1, 2, 0);
    wrByte(2'd1, 8'h01);
    c0 = cyc;
    rdByte(2'd1, d, t);
    check("R3 high-only read", int'(d), ((256 - (t - c0 - 1)) >> 8) & 255);
    waitRise(1, 400, "R3");
    check("R3 high-only count", riseAt[1] - c0, 257);
  endtask

  task automatic tGate();
    int c1; int dummy;
    setup(0, 3, 0);
    @(negedge clk); tickEn = 1'b0;
    loadLoHi(0, 3, dummy);
    repeat (20) @(negedge clk);
    check("R11 no tick no count", int'(chanOut[0]), 0);
    tickEn = 1'b1;
    c1 = cyc;
    waitRise(0, 100, "R11");
    check("R11 counting after enable", riseAt[0] - c1, 4);
    setup(3, 3, 2);
    check("R1 channel select 3 ignored", int'(chanOut[0]), 1);
  endtask

  task automatic tMax();
    int c0;
    setup(0, 3, 0);
    loadLoHi(0, 0, c0);
    waitRise(0, 70000, "R4");
    check("R4 zero count acts as 65536", riseAt[0] - c0, 65537);
  endtask

  task automatic summary();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tOneShot();
    tRate();
    tRateReload();
    tSquare();
    tLatch();
    tByteModes();
    tGate();
    tMax();
    summary();
  end

  initial begin
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end
endmodule